// File: doc/BRIEF.md
# Privileged Trap and Exception Controller

This block is the control unit that sits beside the commit stage of a simple 32-bit core and owns the processor's privilege state. It holds a one-bit privilege mode, a saved copy of the previous mode, a flag that marks a handler as running, the return address of the interrupted program, a code that records why control was taken, and the faulting virtual address of the last page fault. The core presents one instruction per cycle at commit. For that instruction the core also reports any synchronous fault it raised, whether it is a privileged operation or a control-register access, and whether it is a return-from-trap command. Interrupt lines arrive asynchronously to the program and are latched as pending.

When a trap is taken, the whole transfer happens on one clock edge. The return address, the reason and the previous mode are saved, the mode becomes kernel, and in the next cycle the block asks the core to flush every younger instruction and to fetch from the handler vector. The core does not retire the trapping instruction or anything younger. A return command issued by the handler restores the saved mode and redirects fetch to the saved address. A second trap can only be taken after that return. Until then, synchronous faults are dropped and interrupts wait. After reset the core runs in kernel mode from a fixed boot address.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is high and during the first cycle after it falls, `redirect_valid` is 1 and `redirect_pc` is 0xBFC00000. After reset the mode is kernel, the previous-mode bit is 1, no handler is active, and no interrupt is pending.
- R2: A trap is taken on a clock edge where no handler is active and a request is present. In the following cycle `redirect_valid` and `flush` are both 1 for exactly one cycle and `redirect_pc` is 0x80000180. On that edge the saved return address receives `cmd_pc`, the previous-mode bit receives the old mode, the mode becomes 1 (kernel) and the handler becomes active.
- R3: The reason code for a synchronous fault follows `exc_kind`: 0 gives 8 (system call), 1 gives 9 (divide by zero), 2 gives 12 (overflow), 3 gives 4 (bad address), 4 gives 3 (page fault), and 5 to 7 give 31.
- R4: The faulting-address register loads `exc_vaddr` only on a page-fault trap. No other trap, and no dropped nested fault, changes it.
- R5: In user mode (mode 0), a committed instruction that reads or writes a control register, sets `priv_op`, or issues a return command has no effect and raises a trap with code 10. While the mode is user, `csr_rdata` is always 0.
- R6: While a handler is active, a synchronous fault produces no redirect and no flush, and it leaves the return address, the reason code and the faulting address unchanged.
- R7: A pulse on interrupt line i sets a pending bit that stays set until that line is taken. The line is taken when no handler is active, with code 16+i and with return address `cmd_pc`. When several lines are pending, the lowest index wins and the others stay pending.
- R8: When a synchronous request and a pending interrupt reach the same edge, the synchronous trap is taken and the interrupt stays pending. The interrupt is then taken on the edge after the return.
- R9: A return command issued in kernel mode while a handler is active causes, in the next cycle, `redirect_valid` = 1, `flush` = 0 and `redirect_pc` equal to the saved return address. The mode is restored from the previous-mode bit and the handler becomes inactive.
- R10: A return command issued in kernel mode with no handler active changes nothing and produces no redirect. Instead it raises `eret_err` for one cycle.
- R11: In kernel mode, `csr_sel` chooses the register: 0 is status, with bit0 the mode, bit1 the previous mode and bit2 the active flag (read-only); 1 is the return address; 2 is the reason code (5 bits); 3 is the faulting address. A write takes effect on the edge, and a read appears combinationally on `csr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | An instruction is at commit this cycle |
| cmd_pc | input | 32 | PC of the oldest unretired instruction |
| exc_valid | input | 1 | The committing instruction raised a synchronous fault |
| exc_kind | input | 3 | Kind of the synchronous fault |
| exc_vaddr | input | 32 | Virtual address involved in a memory fault |
| priv_op | input | 1 | The committing instruction is a privileged operation |
| csr_re | input | 1 | Control-register read |
| csr_we | input | 1 | Control-register write |
| csr_sel | input | 2 | Control-register select |
| csr_wdata | input | 32 | Control-register write data |
| eret | input | 1 | Return-from-trap command |
| irq_in | input | NIRQ | Interrupt request lines (line 0 is the timer tick) |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | New fetch address |
| flush | output | 1 | Discard all younger instructions |
| kernel_mode | output | 1 | Current privilege mode, 1 = kernel |
| trap_active | output | 1 | A handler is running |
| eret_err | output | 1 | A stray return was ignored |
| csr_rdata | output | 32 | Control-register read data |

## Verification
Every state change in this block lands on the clock edge that samples the request. The redirect, the flush and the error flag are therefore due in the cycle after the stimulus and last one cycle. Register read-back is combinational and is valid in the same cycle as the read command. An interrupt pulse needs one edge to become pending and a second edge to be taken, so its redirect is due two cycles after the pulse. The bench drives inputs on falling edges, advances exactly one rising edge for each command, and samples on the following falling edge. It therefore reads each result at the cycle where it is due, with no slack. It also checks one cycle later that the one-cycle pulses have dropped.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;
    localparam int KIND_W  = 3;
    localparam int SEL_W   = 2;

    localparam logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180;
    localparam logic [XLEN-1:0] BOOT_VEC    = 32'hBFC0_0000;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t C_PGFAULT  = 5'd3;
    localparam cause_t C_BADADDR  = 5'd4;
    localparam cause_t C_SYSCALL  = 5'd8;
    localparam cause_t C_DIVZERO  = 5'd9;
    localparam cause_t C_PRIV     = 5'd10;
    localparam cause_t C_OVERFLOW = 5'd12;
    localparam cause_t C_IRQ_BASE = 5'd16;
    localparam cause_t C_UNKNOWN  = 5'd31;

    // synchronous fault kinds reported by the pipeline
    typedef enum logic [KIND_W-1:0] {
        K_SYSCALL  = 3'd0,
        K_DIVZERO  = 3'd1,
        K_OVERFLOW = 3'd2,
        K_BADADDR  = 3'd3,
        K_PGFAULT  = 3'd4
    } fault_kind_e;

    // control-register select
    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_EPC    = 2'd1,
        SEL_CAUSE  = 2'd2,
        SEL_BADVA  = 2'd3
    } csr_sel_e;

    // decision for trap entry made by the arbiter
    typedef struct packed {
        logic   take;
        logic   from_irq;
        logic   is_pgfault;
        cause_t code;
    } entry_t;

    // non-trap commands that may retire this cycle
    typedef struct packed {
        logic ret;
        logic ret_err;
        logic csr_wr;
    } cmd_t;

    // saved privilege state
    typedef struct packed {
        logic mode;
        logic prev;
        logic active;
    } priv_t;

    function automatic cause_t sync_cause(input logic [KIND_W-1:0] kind);
        cause_t c;
        case (kind)
            K_SYSCALL:  c = C_SYSCALL;
            K_DIVZERO:  c = C_DIVZERO;
            K_OVERFLOW: c = C_OVERFLOW;
            K_BADADDR:  c = C_BADADDR;
            K_PGFAULT:  c = C_PGFAULT;
            default:    c = C_UNKNOWN;
        endcase
        return c;
    endfunction

    function automatic cause_t irq_cause(input int idx);
        return C_IRQ_BASE + cause_t'(idx);
    endfunction

    function automatic logic [XLEN-1:0] pack_status(input priv_t p);
        return {{(XLEN-3){1'b0}}, p.active, p.prev, p.mode};
    endfunction

endpackage

// File: rtl/trap_irq_pending.sv
`timescale 1ns/1ps
module trap_irq_pending #(
    parameter int NIRQ = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] irq_in,
    input  logic [NIRQ-1:0] clr,
    output logic [NIRQ-1:0] pend
);

    genvar gi;
    generate
        for (gi = 0; gi < NIRQ; gi++) begin : g_line
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q <= 1'b0;
                end else begin
                    // a new request wins over a clear on the same edge
                    pend_q <= (pend_q & ~clr[gi]) | irq_in[gi];
                end
            end
            assign pend[gi] = pend_q;
        end
    endgenerate

endmodule

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NIRQ = 2
) (
    input  logic              mode,
    input  logic              active,
    input  logic              cmd_valid,
    input  logic              exc_valid,
    input  logic [KIND_W-1:0] exc_kind,
    input  logic              priv_op,
    input  logic              csr_re,
    input  logic              csr_we,
    input  logic              eret,
    input  logic [NIRQ-1:0]   pend,
    output entry_t            entry,
    output cmd_t              cmd,
    output logic [NIRQ-1:0]   irq_clr
);

    logic            user_viol;
    logic            sync_req;
    logic            irq_any;
    logic [NIRQ-1:0] irq_pick;
    cause_t          irq_code;

    // lowest pending index wins
    always_comb begin
        logic found;
        found    = 1'b0;
        irq_pick = '0;
        irq_code = C_IRQ_BASE;
        for (int i = 0; i < NIRQ; i++) begin
            if (pend[i] && !found) begin
                found       = 1'b1;
                irq_pick[i] = 1'b1;
                irq_code    = irq_cause(i);
            end
        end
        irq_any = found;
    end

    assign user_viol = cmd_valid & ~mode & (csr_re | csr_we | priv_op | eret);
    assign sync_req  = (cmd_valid & exc_valid) | user_viol;

    always_comb begin
        entry.take       = ~active & (sync_req | irq_any);
        entry.from_irq   = ~sync_req;
        entry.is_pgfault = 1'b0;
        entry.code       = irq_code;
        if (sync_req) begin
            if (cmd_valid && exc_valid) begin
                entry.code       = sync_cause(exc_kind);
                entry.is_pgfault = (exc_kind == K_PGFAULT);
            end else begin
                entry.code = C_PRIV;
            end
        end
    end

    assign irq_clr = (entry.take && entry.from_irq) ? irq_pick : '0;

    always_comb begin
        logic clean;
        clean       = cmd_valid & mode & ~exc_valid & ~entry.take;
        cmd.ret     = clean & eret & active;
        cmd.ret_err = clean & eret & ~active;
        cmd.csr_wr  = clean & csr_we & ~eret;
    end

endmodule

// File: rtl/trap_state.sv
`timescale 1ns/1ps
module trap_state
    import trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  entry_t           entry,
    input  cmd_t             cmd,
    input  logic [XLEN-1:0]  cmd_pc,
    input  logic [XLEN-1:0]  exc_vaddr,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] csr_sel,
    input  logic [XLEN-1:0]  csr_wdata,
    output priv_t            priv,
    output logic [XLEN-1:0]  epc,
    output logic [XLEN-1:0]  csr_rdata,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic             flush,
    output logic             eret_err
);

    priv_t           priv_q;
    logic [XLEN-1:0] epc_q;
    cause_t          cause_q;
    logic [XLEN-1:0] badva_q;
    csr_sel_e        sel;

    assign sel = csr_sel_e'(csr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q         <= '{mode: 1'b1, prev: 1'b1, active: 1'b0};
            epc_q          <= '0;
            cause_q        <= '0;
            badva_q        <= '0;
            redirect_valid <= 1'b1;
            redirect_pc    <= BOOT_VEC;
            flush          <= 1'b0;
            eret_err       <= 1'b0;
        end else begin
            redirect_valid <= 1'b0;
            flush          <= 1'b0;
            eret_err       <= cmd.ret_err;
            if (entry.take) begin
                epc_q          <= cmd_pc;
                cause_q        <= entry.code;
                priv_q.prev    <= priv_q.mode;
                priv_q.mode    <= 1'b1;
                priv_q.active  <= 1'b1;
                if (entry.is_pgfault) begin
                    badva_q <= exc_vaddr;
                end
                redirect_valid <= 1'b1;
                redirect_pc    <= HANDLER_VEC;
                flush          <= 1'b1;
            end else if (cmd.ret) begin
                priv_q.mode    <= priv_q.prev;
                priv_q.active  <= 1'b0;
                redirect_valid <= 1'b1;
                redirect_pc    <= epc_q;
            end else if (cmd.csr_wr) begin
                case (sel)
                    SEL_STATUS: begin
                        priv_q.mode <= csr_wdata[0];
                        priv_q.prev <= csr_wdata[1];
                    end
                    SEL_EPC:   epc_q   <= csr_wdata;
                    SEL_CAUSE: cause_q <= csr_wdata[CAUSE_W-1:0];
                    SEL_BADVA: badva_q <= csr_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (rd_en && priv_q.mode) begin
            case (sel)
                SEL_STATUS: csr_rdata = pack_status(priv_q);
                SEL_EPC:    csr_rdata = epc_q;
                SEL_CAUSE:  csr_rdata = {{(XLEN-CAUSE_W){1'b0}}, cause_q};
                SEL_BADVA:  csr_rdata = badva_q;
                default:    csr_rdata = '0;
            endcase
        end
    end

    assign priv = priv_q;
    assign epc  = epc_q;

endmodule

// File: rtl/trap_ctrl.sv
`timescale 1ns/1ps
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int NIRQ = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [XLEN-1:0]        cmd_pc,
    input  logic                   exc_valid,
    input  logic [KIND_W-1:0]      exc_kind,
    input  logic [XLEN-1:0]        exc_vaddr,
    input  logic                   priv_op,
    input  logic                   csr_re,
    input  logic                   csr_we,
    input  logic [SEL_W-1:0]       csr_sel,
    input  logic [XLEN-1:0]        csr_wdata,
    input  logic                   eret,
    input  logic [NIRQ-1:0]        irq_in,
    output logic                   redirect_valid,
    output logic [XLEN-1:0]        redirect_pc,
    output logic                   flush,
    output logic                   kernel_mode,
    output logic                   trap_active,
    output logic                   eret_err,
    output logic [XLEN-1:0]        csr_rdata
);

    localparam int MAX_IRQ = (1 << CAUSE_W) - 1 - int'(C_IRQ_BASE);

    entry_t          entry;
    cmd_t            cmd;
    priv_t           priv;
    logic [NIRQ-1:0] pend;
    logic [NIRQ-1:0] irq_clr;
    logic [XLEN-1:0] epc;

    initial begin
        if (NIRQ < 1 || NIRQ > MAX_IRQ) begin
            $error("NIRQ out of range for the reason-code space");
        end
    end

    trap_irq_pending #(.NIRQ(NIRQ)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .clr    (irq_clr),
        .pend   (pend)
    );

    trap_arbiter #(.NIRQ(NIRQ)) u_arb (
        .mode      (priv.mode),
        .active    (priv.active),
        .cmd_valid (cmd_valid),
        .exc_valid (exc_valid),
        .exc_kind  (exc_kind),
        .priv_op   (priv_op),
        .csr_re    (csr_re),
        .csr_we    (csr_we),
        .eret      (eret),
        .pend      (pend),
        .entry     (entry),
        .cmd       (cmd),
        .irq_clr   (irq_clr)
    );

    trap_state u_state (
        .clk            (clk),
        .rst            (rst),
        .entry          (entry),
        .cmd            (cmd),
        .cmd_pc         (cmd_pc),
        .exc_vaddr      (exc_vaddr),
        .rd_en          (cmd_valid & csr_re),
        .csr_sel        (csr_sel),
        .csr_wdata      (csr_wdata),
        .priv           (priv),
        .epc            (epc),
        .csr_rdata      (csr_rdata),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .flush          (flush),
        .eret_err       (eret_err)
    );

    assign kernel_mode = priv.mode;
    assign trap_active = priv.active;

endmodule

// File: rtl/trap_ctrl_chk.sv
`timescale 1ns/1ps
module trap_ctrl_chk
    import trap_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            flush,
    input logic            kernel_mode,
    input logic            trap_active,
    input logic            eret_err,
    input logic [XLEN-1:0] csr_rdata,
    input logic [XLEN-1:0] epc
);

    // R1
    boot_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (redirect_valid && redirect_pc == BOOT_VEC && kernel_mode && !trap_active));

    // R2
    entry_vector_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> (redirect_valid && redirect_pc == HANDLER_VEC && kernel_mode && trap_active));

    // R6
    no_nested_chk: assert property (@(posedge clk) disable iff (rst)
        $past(trap_active) |-> !flush);

    // R9
    return_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && !flush && !$past(rst)) |-> (!trap_active && $past(trap_active)));

    // R10
    stray_return_chk: assert property (@(posedge clk) disable iff (rst)
        eret_err |-> (!redirect_valid && !trap_active && $stable(epc)));

    // R5
    user_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !kernel_mode |-> (csr_rdata == '0));

endmodule

bind trap_ctrl trap_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .flush          (flush),
    .kernel_mode    (kernel_mode),
    .trap_active    (trap_active),
    .eret_err       (eret_err),
    .csr_rdata      (csr_rdata),
    .epc            (epc)
);

// File: tb/trap_ctrl_test.sv
`timescale 1ns/1ps
module trap_ctrl_test;

    localparam int NIRQ = 2;
    localparam logic [31:0] VEC  = 32'h8000_0180;
    localparam logic [31:0] BOOT = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, exc_valid, priv_op, csr_re, csr_we, eret;
    logic [31:0] cmd_pc, exc_vaddr, csr_wdata;
    logic [2:0]  exc_kind;
    logic [1:0]  csr_sel;
    logic [NIRQ-1:0] irq_in;
    logic        redirect_valid, flush, kernel_mode, trap_active, eret_err;
    logic [31:0] redirect_pc, csr_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    // expected state
    logic        m_mode, m_prev, m_active;
    logic [31:0] m_epc, m_cause, m_bva;

    always #2.5 clk = ~clk;

    trap_ctrl #(.NIRQ(NIRQ)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_pc(cmd_pc),
        .exc_valid(exc_valid), .exc_kind(exc_kind), .exc_vaddr(exc_vaddr),
        .priv_op(priv_op), .csr_re(csr_re), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .eret(eret), .irq_in(irq_in),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush(flush),
        .kernel_mode(kernel_mode), .trap_active(trap_active), .eret_err(eret_err),
        .csr_rdata(csr_rdata)
    );

    function automatic logic [31:0] kind_code(input int k);
        case (k)
            0: return 32'd8;
            1: return 32'd9;
            2: return 32'd12;
            3: return 32'd4;
            4: return 32'd3;
            default: return 32'd31;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = 0; exc_valid = 0; priv_op = 0; csr_re = 0; csr_we = 0; eret = 0;
        exc_kind = 0; csr_sel = 0; csr_wdata = 0; exc_vaddr = 0; irq_in = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic csr_read(input int sel, output logic [31:0] d);
        cmd_valid = 1; csr_re = 1; csr_sel = sel[1:0];
        #1;
        d = csr_rdata;
        idle();
    endtask

    task automatic csr_write(input int sel, input logic [31:0] d);
        cmd_valid = 1; csr_we = 1; csr_sel = sel[1:0]; csr_wdata = d;
        step();
        idle();
        if (m_mode) begin
            case (sel)
                0: begin m_mode = d[0]; m_prev = d[1]; end
                1: m_epc = d;
                2: m_cause = {27'd0, d[4:0]};
                default: m_bva = d;
            endcase
        end
    endtask

    task automatic model_trap(input logic [31:0] code, input logic [31:0] pc);
        m_epc = pc; m_cause = code; m_prev = m_mode; m_mode = 1; m_active = 1;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] d;
        csr_read(0, d); chk({tag, " status"}, d, {29'd0, m_active, m_prev, m_mode});
        csr_read(1, d); chk({tag, " epc"}, d, m_epc);
        csr_read(2, d); chk({tag, " cause"}, d, m_cause);
        csr_read(3, d); chk({tag, " badva"}, d, m_bva);
    endtask

    task automatic expect_entry(input string tag);
        chk({tag, " redirect"}, {30'd0, redirect_valid, flush}, 32'd3);
        chk({tag, " vector"}, redirect_pc, VEC);
    endtask

    task automatic sync_trap(input int kind, input logic [31:0] pc, input logic [31:0] va);
        cmd_valid = 1; exc_valid = 1; exc_kind = kind[2:0]; cmd_pc = pc; exc_vaddr = va;
        step();
        idle();
    endtask

    task automatic do_eret(input logic [31:0] pc);
        cmd_valid = 1; eret = 1; cmd_pc = pc;
        step();
        idle();
    endtask

    task automatic ret_and_check(input string tag);
        do_eret(32'h0000_0F00);
        chk({tag, " R9 redirect"}, {30'd0, redirect_valid, flush}, 32'd2);
        chk({tag, " R9 target"}, redirect_pc, m_epc);
        m_mode = m_prev; m_active = 0;
        chk({tag, " R9 mode"}, {31'd0, kernel_mode}, {31'd0, m_mode});
    endtask

    task automatic back_to_kernel();
        sync_trap(0, 32'h0050_0000, 32'h0);
        model_trap(32'd8, 32'h0050_0000);
        csr_write(0, 32'h3);
        ret_and_check("restore");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle();
        cmd_pc = 0;
        rst = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: boot redirect still shown in first cycle after reset
        chk("R1 boot redirect", {31'd0, redirect_valid}, 32'd1);
        chk("R1 boot pc", redirect_pc, BOOT);
        step();
        chk("R1 redirect drops", {31'd0, redirect_valid}, 32'd0);
        m_mode = 1; m_prev = 1; m_active = 0; m_epc = 0; m_cause = 0; m_bva = 0;
        check_regs("R1 reset");

        // R2 R3 R4 R6 R9: sweep kinds from both modes
        for (int k = 0; k < 6; k++) begin
            for (int um = 0; um < 2; um++) begin
                logic [31:0] pc, va;
                pc = 32'h0040_0000 + k * 16 + um * 4;
                va = 32'h1000_0000 + k * 256 + um;
                if (um == 1) csr_write(0, 32'h0);
                else         csr_write(0, 32'h3);
                sync_trap(k, pc, va);
                expect_entry("R2 sync");
                model_trap(kind_code(k), pc);
                if (k == 4) m_bva = va;
                check_regs("R3 R4 entry");
                // R6: nested fault dropped
                sync_trap(4, pc + 32'h100, va + 32'h8);
                chk("R6 nested no redirect", {30'd0, redirect_valid, flush}, 32'd0);
                check_regs("R6 nested");
                ret_and_check("sweep");
                if (!m_mode) back_to_kernel();
                else check_regs("R9 after return");
            end
        end

        // R10: stray return in kernel
        do_eret(32'h0000_1234);
        chk("R10 no redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R10 err flag", {31'd0, eret_err}, 32'd1);
        step();
        chk("R10 err one cycle", {31'd0, eret_err}, 32'd0);
        check_regs("R10 unchanged");

        // R11: kernel register writes
        csr_write(1, 32'hCAFE_0010);
        csr_write(2, 32'h0000_003F);
        csr_write(3, 32'h7777_0000);
        check_regs("R11 writes");

        // R5: user-mode privileged accesses
        csr_write(0, 32'h0);
        csr_read(1, d);
        chk("R5 user read zero", d, 32'h0);
        cmd_pc = 32'h0060_0000;
        csr_write(3, 32'hDEAD_BEEF);
        expect_entry("R5 csr write");
        model_trap(32'd10, 32'h0060_0000);
        check_regs("R5 write blocked");
        ret_and_check("R5a");
        cmd_valid = 1; priv_op = 1; cmd_pc = 32'h0060_0010;
        step(); idle();
        expect_entry("R5 priv op");
        model_trap(32'd10, 32'h0060_0010);
        check_regs("R5 priv op");
        ret_and_check("R5b");
        do_eret(32'h0060_0020);
        expect_entry("R5 user eret");
        model_trap(32'd10, 32'h0060_0020);
        check_regs("R5 user eret");
        ret_and_check("R5c");
        back_to_kernel();

        // R7: single interrupt line 1
        cmd_pc = 32'h0070_0000;
        irq_in = 2'b10;
        step();
        irq_in = '0;
        chk("R7 pending not yet taken", {31'd0, redirect_valid}, 32'd0);
        step();
        expect_entry("R7 irq1");
        model_trap(32'd17, 32'h0070_0000);
        check_regs("R7 irq1");
        ret_and_check("R7a");

        // R7: both lines, lowest index first, other stays pending
        cmd_pc = 32'h0070_0100;
        irq_in = 2'b11;
        step();
        irq_in = '0;
        step();
        expect_entry("R7 both");
        model_trap(32'd16, 32'h0070_0100);
        check_regs("R7 tick first");
        step();
        chk("R7 held while active", {31'd0, redirect_valid}, 32'd0);
        ret_and_check("R7b");
        cmd_pc = 32'h0070_0200;
        step();
        expect_entry("R7 second line");
        model_trap(32'd17, 32'h0070_0200);
        check_regs("R7 line1 after return");
        ret_and_check("R7c");

        // R8: sync beats pending interrupt
        irq_in = 2'b01;
        step();
        irq_in = '0;
        sync_trap(0, 32'h0080_0000, 32'h0);
        expect_entry("R8 sync wins");
        model_trap(32'd8, 32'h0080_0000);
        check_regs("R8 sync cause");
        ret_and_check("R8a");
        cmd_pc = 32'h0080_0040;
        step();
        expect_entry("R8 irq after return");
        model_trap(32'd16, 32'h0080_0040);
        check_regs("R8 irq cause");
        ret_and_check("R8b");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule